// File: doc/BRIEF.md
# Privilege Mode Trap Controller

This block holds the current privilege level of a small processor core (user, supervisor or machine) and performs the level changes that traps and trap returns cause. A trap request carries a cause code, a flag that marks it as an interrupt rather than an exception, the program counter of the trapping instruction and a faulting address. Two per-cause delegation masks decide whether a trap raised below machine level is handled at supervisor or at machine level. The block then loads the handler base for that level and records the return state.

Each of the two handling levels keeps its own saved state. This state is a stacked copy of its interrupt-enable bit, the previous privilege level, the return PC, the cause word and the trap value. The matching return strobe pops this stack, restores the saved level and redirects fetch to the saved PC. Every redirect appears one cycle after the request as a registered target PC with a one-cycle valid pulse. Instruction decode, software access to the saved state and the pipeline sit outside the block, and the handler base is always used directly, never indexed by cause.

Top module: `priv_trap_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the level is machine (`cur_mode` = 2'b11). `pc_valid` is 0. Both enable bits and both previous-enable bits are 0. Both previous-level fields are user (0). Every saved PC, cause and trap value is 0. The level encoding is 2'b00 user, 2'b01 supervisor, 2'b11 machine, and 2'b10 never appears.
- R2: A trap raised at user or supervisor level goes to supervisor level when the mask bit indexed by the cause code is 1, and to machine level otherwise. The mask is `deleg_irq` for an interrupt and `deleg_exc` for an exception. A trap raised at machine level always goes to machine level, whatever the masks hold.
- R3: One cycle after a trap to machine level, `cur_mode` is 2'b11, `pc_next` equals `m_vec_base`, `pc_valid` is 1, and `m_prev_mode` holds the level the trap was raised from (2-bit level code).
- R4: One cycle after a trap to supervisor level, `cur_mode` is 2'b01, `pc_next` equals `s_vec_base`, `pc_valid` is 1, and `s_prev_mode` is 0 when the trap came from user level and 1 when it came from supervisor level.
- R5: The target level's saved PC takes `trap_pc`. Its cause word takes the interrupt flag in bit 31 and the cause code in its low bits, with zeros in between.
- R6: The target level's trap value takes `trap_addr` when the trap is an exception with cause code 0, 1, 4, 5, 6 or 7 (misaligned or access-fault codes). It takes zero for every other exception code and for every interrupt.
- R7: On trap entry, the target level's previous-enable bit takes its enable bit and its enable bit is cleared. The other level's enable, previous-enable and saved state do not change.
- R8: One cycle after `ret_m`, `cur_mode` equals the old `m_prev_mode` and `pc_next` equals `m_epc`. `m_ie` takes the old `m_pie`, `m_pie` becomes 1 and `m_prev_mode` becomes user (2'b00).
- R9: One cycle after `ret_s`, `cur_mode` equals {0, old `s_prev_mode`} and `pc_next` equals `s_epc`. `s_ie` takes the old `s_pie`, `s_pie` becomes 1 and `s_prev_mode` becomes 0.
- R10: A trap request takes priority over a return strobe in the same cycle, and that return has no effect. When both return strobes are high without a trap, the machine-level return is taken and the supervisor-level state is unchanged.
- R11: In a cycle with no trap and no return, the next cycle shows `pc_valid` at 0 and the level and all saved state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Trap request this cycle |
| trap_is_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | CAUSE_W | Cause code |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_addr | input | XLEN | Faulting address |
| deleg_exc | input | XLEN | Per-cause exception delegation mask |
| deleg_irq | input | XLEN | Per-cause interrupt delegation mask |
| m_vec_base | input | XLEN | Machine-level handler address |
| s_vec_base | input | XLEN | Supervisor-level handler address |
| ret_m | input | 1 | Machine-level return strobe |
| ret_s | input | 1 | Supervisor-level return strobe |
| cur_mode | output | 2 | Current privilege level |
| pc_valid | output | 1 | One-cycle pulse: fetch must redirect to pc_next |
| pc_next | output | XLEN | Redirect target |
| m_ie | output | 1 | Machine-level interrupt enable |
| m_pie | output | 1 | Machine-level stacked enable |
| m_prev_mode | output | 2 | Level to return to from machine level |
| m_epc | output | XLEN | Machine-level saved PC |
| m_cause | output | XLEN | Machine-level cause word |
| m_tval | output | XLEN | Machine-level trap value |
| s_ie | output | 1 | Supervisor-level interrupt enable |
| s_pie | output | 1 | Supervisor-level stacked enable |
| s_prev_mode | output | 1 | Level to return to from supervisor level |
| s_epc | output | XLEN | Supervisor-level saved PC |
| s_cause | output | XLEN | Supervisor-level cause word |
| s_tval | output | XLEN | Supervisor-level trap value |

## Verification
The properties assume that the delegation masks and both handler bases are stable through the cycle in which they are sampled. They also assume that `trap_cause` is below `XLEN`, so that it indexes a real mask bit. The block does not judge whether a return is legal at the current level. The bench therefore drives all inputs only at the falling edge and holds the masks and bases constant. Cause codes stay small. Returns from an unexpected level appear only where the stack behaviour itself is under test.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  localparam logic [1:0] LVL_U = 2'b00;
  localparam logic [1:0] LVL_S = 2'b01;
  localparam logic [1:0] LVL_M = 2'b11;

  // Exception codes whose trap value carries the faulting address
  function automatic logic code_has_addr(input logic [7:0] code);
    logic hit;
    case (code)
      8'd0, 8'd1, 8'd4, 8'd5, 8'd6, 8'd7: hit = 1'b1;
      default:                            hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/ptc_route.sv
module ptc_route
  import ptc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               trap_req,
  input  logic               trap_is_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [1:0]         cur_mode,
  input  logic [XLEN-1:0]    deleg_exc,
  input  logic [XLEN-1:0]    deleg_irq,
  input  logic [XLEN-1:0]    trap_addr,
  output logic               go_m,
  output logic               go_s,
  output logic [XLEN-1:0]    tval_val
);

  logic deleg_bit;
  logic below_m;

  always_comb begin
    deleg_bit = trap_is_irq ? deleg_irq[trap_cause] : deleg_exc[trap_cause];
    below_m   = (cur_mode != LVL_M);
    go_s      = trap_req && below_m && deleg_bit;
    go_m      = trap_req && !go_s;
    if (!trap_is_irq && code_has_addr(8'(trap_cause)))
      tval_val = trap_addr;
    else
      tval_val = '0;
  end

endmodule

// File: rtl/ptc_level.sv
module ptc_level #(
  parameter int XLEN = 32,
  parameter int PP_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            ret,
  input  logic [PP_W-1:0] prev_in,
  input  logic [XLEN-1:0] epc_in,
  input  logic [XLEN-1:0] cause_in,
  input  logic [XLEN-1:0] tval_in,
  output logic            ie,
  output logic            pie,
  output logic [PP_W-1:0] pp,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] cause,
  output logic [XLEN-1:0] tval
);

  logic            ie_q, ie_d, pie_q, pie_d;
  logic [PP_W-1:0] pp_q, pp_d;
  logic [XLEN-1:0] epc_q, epc_d, cause_q, cause_d, tval_q, tval_d;
  logic            upd_en;

  always_comb begin
    ie_d    = ie_q;
    pie_d   = pie_q;
    pp_d    = pp_q;
    epc_d   = epc_q;
    cause_d = cause_q;
    tval_d  = tval_q;
    if (take) begin
      pie_d   = ie_q;
      ie_d    = 1'b0;
      pp_d    = prev_in;
      epc_d   = epc_in;
      cause_d = cause_in;
      tval_d  = tval_in;
    end else if (ret) begin
      ie_d  = pie_q;
      pie_d = 1'b1;
      pp_d  = '0;
    end
    upd_en = take || ret;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q    <= 1'b0;
      pie_q   <= 1'b0;
      pp_q    <= '0;
      epc_q   <= '0;
      cause_q <= '0;
      tval_q  <= '0;
    end else if (upd_en) begin
      ie_q    <= ie_d;
      pie_q   <= pie_d;
      pp_q    <= pp_d;
      epc_q   <= epc_d;
      cause_q <= cause_d;
      tval_q  <= tval_d;
    end
  end

  assign ie    = ie_q;
  assign pie   = pie_q;
  assign pp    = pp_q;
  assign epc   = epc_q;
  assign cause = cause_q;
  assign tval  = tval_q;

endmodule

// File: rtl/ptc_flow.sv
module ptc_flow
  import ptc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_m,
  input  logic            go_s,
  input  logic            do_mret,
  input  logic            do_sret,
  input  logic [XLEN-1:0] m_vec,
  input  logic [XLEN-1:0] s_vec,
  input  logic [XLEN-1:0] m_epc,
  input  logic [XLEN-1:0] s_epc,
  input  logic [1:0]      m_pp,
  input  logic            s_pp,
  output logic [1:0]      mode,
  output logic            pc_valid,
  output logic [XLEN-1:0] pc_next
);

  logic [1:0]      mode_q, mode_d;
  logic [XLEN-1:0] pc_q, pc_d;
  logic            vld_q, vld_d;
  logic            upd_en;

  always_comb begin
    mode_d = mode_q;
    pc_d   = pc_q;
    vld_d  = 1'b0;
    if (go_m) begin
      mode_d = LVL_M;
      pc_d   = m_vec;
      vld_d  = 1'b1;
    end else if (go_s) begin
      mode_d = LVL_S;
      pc_d   = s_vec;
      vld_d  = 1'b1;
    end else if (do_mret) begin
      mode_d = m_pp;
      pc_d   = m_epc;
      vld_d  = 1'b1;
    end else if (do_sret) begin
      mode_d = {1'b0, s_pp};
      pc_d   = s_epc;
      vld_d  = 1'b1;
    end
    upd_en = vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= LVL_M;
      pc_q   <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (upd_en) begin
        mode_q <= mode_d;
        pc_q   <= pc_d;
      end
    end
  end

  assign mode     = mode_q;
  assign pc_valid = vld_q;
  assign pc_next  = pc_q;

endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_req,
  input  logic               trap_is_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic [XLEN-1:0]    trap_addr,
  input  logic [XLEN-1:0]    deleg_exc,
  input  logic [XLEN-1:0]    deleg_irq,
  input  logic [XLEN-1:0]    m_vec_base,
  input  logic [XLEN-1:0]    s_vec_base,
  input  logic               ret_m,
  input  logic               ret_s,
  output logic [1:0]         cur_mode,
  output logic               pc_valid,
  output logic [XLEN-1:0]    pc_next,
  output logic               m_ie,
  output logic               m_pie,
  output logic [1:0]         m_prev_mode,
  output logic [XLEN-1:0]    m_epc,
  output logic [XLEN-1:0]    m_cause,
  output logic [XLEN-1:0]    m_tval,
  output logic               s_ie,
  output logic               s_pie,
  output logic               s_prev_mode,
  output logic [XLEN-1:0]    s_epc,
  output logic [XLEN-1:0]    s_cause,
  output logic [XLEN-1:0]    s_tval
);

  localparam int PAD_W = XLEN - 1 - CAUSE_W;

  logic            go_m, go_s, do_mret, do_sret;
  logic [XLEN-1:0] tval_val, cause_word;

  // R10: a trap overrides both returns; machine return overrides supervisor return
  assign do_mret    = ret_m && !trap_req;
  assign do_sret    = ret_s && !trap_req && !ret_m;
  assign cause_word = {trap_is_irq, {PAD_W{1'b0}}, trap_cause};

  ptc_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_route (
    .trap_req    (trap_req),
    .trap_is_irq (trap_is_irq),
    .trap_cause  (trap_cause),
    .cur_mode    (cur_mode),
    .deleg_exc   (deleg_exc),
    .deleg_irq   (deleg_irq),
    .trap_addr   (trap_addr),
    .go_m        (go_m),
    .go_s        (go_s),
    .tval_val    (tval_val)
  );

  ptc_level #(.XLEN(XLEN), .PP_W(2)) u_lvl_m (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (go_m),
    .ret      (do_mret),
    .prev_in  (cur_mode),
    .epc_in   (trap_pc),
    .cause_in (cause_word),
    .tval_in  (tval_val),
    .ie       (m_ie),
    .pie      (m_pie),
    .pp       (m_prev_mode),
    .epc      (m_epc),
    .cause    (m_cause),
    .tval     (m_tval)
  );

  ptc_level #(.XLEN(XLEN), .PP_W(1)) u_lvl_s (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (go_s),
    .ret      (do_sret),
    .prev_in  (cur_mode[0]),
    .epc_in   (trap_pc),
    .cause_in (cause_word),
    .tval_in  (tval_val),
    .ie       (s_ie),
    .pie      (s_pie),
    .pp       (s_prev_mode),
    .epc      (s_epc),
    .cause    (s_cause),
    .tval     (s_tval)
  );

  ptc_flow #(.XLEN(XLEN)) u_flow (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_m     (go_m),
    .go_s     (go_s),
    .do_mret  (do_mret),
    .do_sret  (do_sret),
    .m_vec    (m_vec_base),
    .s_vec    (s_vec_base),
    .m_epc    (m_epc),
    .s_epc    (s_epc),
    .m_pp     (m_prev_mode),
    .s_pp     (s_prev_mode),
    .mode     (cur_mode),
    .pc_valid (pc_valid),
    .pc_next  (pc_next)
  );

endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               trap_req,
  input logic               trap_is_irq,
  input logic [CAUSE_W-1:0] trap_cause,
  input logic [XLEN-1:0]    trap_pc,
  input logic [XLEN-1:0]    deleg_exc,
  input logic [XLEN-1:0]    deleg_irq,
  input logic [XLEN-1:0]    m_vec_base,
  input logic [XLEN-1:0]    s_vec_base,
  input logic               ret_m,
  input logic               ret_s,
  input logic [1:0]         cur_mode,
  input logic               pc_valid,
  input logic [XLEN-1:0]    pc_next,
  input logic               m_ie,
  input logic               m_pie,
  input logic [1:0]         m_prev_mode,
  input logic [XLEN-1:0]    m_epc,
  input logic [XLEN-1:0]    m_tval,
  input logic               s_ie,
  input logic               s_pie,
  input logic               s_prev_mode,
  input logic [XLEN-1:0]    s_epc
);

  logic sel_bit;
  assign sel_bit = trap_is_irq ? deleg_irq[trap_cause] : deleg_exc[trap_cause];

  assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cur_mode != 2'b10);

  assert_m_no_deleg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && cur_mode == 2'b11 |=>
      cur_mode == 2'b11 && pc_next == $past(m_vec_base) && m_prev_mode == 2'b11);

  assert_m_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && cur_mode != 2'b11 && !sel_bit |=>
      pc_valid && cur_mode == 2'b11 && pc_next == $past(m_vec_base) &&
      m_prev_mode == $past(cur_mode));

  assert_s_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && cur_mode != 2'b11 && sel_bit |=>
      pc_valid && cur_mode == 2'b01 && pc_next == $past(s_vec_base) &&
      s_prev_mode == $past(cur_mode[0]));

  assert_epc_saved_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (m_epc == $past(trap_pc)) || (s_epc == $past(trap_pc)));

  assert_irq_tval_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && trap_is_irq && cur_mode == 2'b11 |=> m_tval == '0);

  assert_entry_stack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && cur_mode == 2'b11 |=>
      !m_ie && m_pie == $past(m_ie) && s_ie == $past(s_ie) && s_pie == $past(s_pie));

  assert_mret_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_m && !trap_req |=>
      pc_valid && cur_mode == $past(m_prev_mode) && pc_next == $past(m_epc) &&
      m_ie == $past(m_pie) && m_pie && m_prev_mode == 2'b00);

  assert_sret_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_s && !ret_m && !trap_req |=>
      pc_valid && cur_mode == {1'b0, $past(s_prev_mode)} && pc_next == $past(s_epc) &&
      s_ie == $past(s_pie) && s_pie && !s_prev_mode);

  assert_trap_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && (ret_m || ret_s) |=>
      pc_valid && (pc_next == $past(m_vec_base) || pc_next == $past(s_vec_base)));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req && !ret_m && !ret_s |=>
      !pc_valid && $stable(cur_mode) && $stable(m_epc) && $stable(s_epc) &&
      $stable(m_ie) && $stable(s_ie));

endmodule

bind priv_trap_ctrl ptc_checker #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (.*);

// File: tb/priv_trap_ctrl_test.sv
module priv_trap_ctrl_test;

  logic        clk, rst_n;
  logic        trap_req, trap_is_irq, ret_m, ret_s;
  logic [4:0]  trap_cause;
  logic [31:0] trap_pc, trap_addr, deleg_exc, deleg_irq, m_vec_base, s_vec_base;
  logic [1:0]  cur_mode, m_prev_mode;
  logic        pc_valid, m_ie, m_pie, s_ie, s_pie, s_prev_mode;
  logic [31:0] pc_next, m_epc, m_cause, m_tval, s_epc, s_cause, s_tval;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  priv_trap_ctrl uut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [1:0]  op;      // 0 trap, 1 machine return, 2 supervisor return
    logic        irq;
    logic [4:0]  cause;
    logic [31:0] pc;
    logic [31:0] addr;
    logic [1:0]  e_mode;
    logic [31:0] e_pc;
    logic [1:0]  e_pp;
    logic [31:0] e_cause;
    logic [31:0] e_tval;
  } vec_t;

  localparam vec_t VECS [0:11] = '{
    '{2'd1, 1'b0, 5'd0, 32'h0,    32'h0,    2'b00, 32'h0,    2'b00, 32'h0,        32'h0},
    '{2'd0, 1'b0, 5'd2, 32'h1000, 32'hDEAD, 2'b01, 32'h200,  2'b00, 32'h2,        32'h0},
    '{2'd0, 1'b0, 5'd5, 32'h2004, 32'hBEEF, 2'b01, 32'h200,  2'b01, 32'h5,        32'hBEEF},
    '{2'd2, 1'b0, 5'd0, 32'h0,    32'h0,    2'b01, 32'h2004, 2'b00, 32'h0,        32'h0},
    '{2'd2, 1'b0, 5'd0, 32'h0,    32'h0,    2'b00, 32'h2004, 2'b00, 32'h0,        32'h0},
    '{2'd0, 1'b1, 5'd7, 32'h3000, 32'h1,    2'b11, 32'h100,  2'b00, 32'h80000007, 32'h0},
    '{2'd0, 1'b0, 5'd2, 32'h104,  32'h55,   2'b11, 32'h100,  2'b11, 32'h2,        32'h0},
    '{2'd1, 1'b0, 5'd0, 32'h0,    32'h0,    2'b11, 32'h104,  2'b00, 32'h0,        32'h0},
    '{2'd1, 1'b0, 5'd0, 32'h0,    32'h0,    2'b00, 32'h104,  2'b00, 32'h0,        32'h0},
    '{2'd0, 1'b1, 5'd5, 32'h4000, 32'h99,   2'b01, 32'h200,  2'b00, 32'h80000005, 32'h0},
    '{2'd0, 1'b0, 5'd6, 32'h4444, 32'h77,   2'b11, 32'h100,  2'b01, 32'h6,        32'h77},
    '{2'd1, 1'b0, 5'd0, 32'h0,    32'h0,    2'b01, 32'h4444, 2'b00, 32'h0,        32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic tr, input logic irq, input logic [4:0] cause,
                       input logic [31:0] pc, input logic [31:0] addr,
                       input logic rm, input logic rs);
    @(negedge clk);
    trap_req = tr; trap_is_irq = irq; trap_cause = cause;
    trap_pc = pc; trap_addr = addr; ret_m = rm; ret_s = rs;
    @(negedge clk);
    trap_req = 1'b0; trap_is_irq = 1'b0; trap_cause = '0;
    trap_pc = '0; trap_addr = '0; ret_m = 1'b0; ret_s = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    trap_req = 0; trap_is_irq = 0; trap_cause = '0; trap_pc = '0; trap_addr = '0;
    ret_m = 0; ret_s = 0;
    deleg_exc  = 32'h0000_0024;   // exception codes 2 and 5 delegated
    deleg_irq  = 32'h0000_0020;   // interrupt code 5 delegated
    m_vec_base = 32'h100;
    s_vec_base = 32'h200;
    do_reset();

    // R1 reset state
    chk("R1 mode", {30'd0, cur_mode}, 32'h3);
    chk("R1 valid", {31'd0, pc_valid}, 32'h0);
    chk("R1 enables", {28'd0, m_ie, m_pie, s_ie, s_pie}, 32'h0);
    chk("R1 prev", {29'd0, m_prev_mode, s_prev_mode}, 32'h0);
    chk("R1 saved", m_epc | s_epc | m_cause | s_cause | m_tval | s_tval, 32'h0);

    // Table: R2 routing, R3/R4 entry, R5 cause/epc, R6 trap value, R8/R9 returns
    for (int i = 0; i < 12; i++) begin
      vec_t v;
      v = VECS[i];
      drive(v.op == 2'd0, v.irq, v.cause, v.pc, v.addr, v.op == 2'd1, v.op == 2'd2);
      chk($sformatf("R2 mode vec%0d", i), {30'd0, cur_mode}, {30'd0, v.e_mode});
      chk($sformatf("R3/R4/R8/R9 pc vec%0d", i), pc_next, v.e_pc);
      chk($sformatf("R3/R4 valid vec%0d", i), {31'd0, pc_valid}, 32'h1);
      if (v.op == 2'd0) begin
        if (v.e_mode == 2'b11) begin
          chk($sformatf("R3 prev vec%0d", i), {30'd0, m_prev_mode}, {30'd0, v.e_pp});
          chk($sformatf("R5 epc vec%0d", i), m_epc, v.pc);
          chk($sformatf("R5 cause vec%0d", i), m_cause, v.e_cause);
          chk($sformatf("R6 tval vec%0d", i), m_tval, v.e_tval);
        end else begin
          chk($sformatf("R4 prev vec%0d", i), {31'd0, s_prev_mode}, {30'd0, v.e_pp});
          chk($sformatf("R5 epc vec%0d", i), s_epc, v.pc);
          chk($sformatf("R5 cause vec%0d", i), s_cause, v.e_cause);
          chk($sformatf("R6 tval vec%0d", i), s_tval, v.e_tval);
        end
      end
    end

    // Enable stacks: R7, R8, R9
    do_reset();
    drive(0, 0, 0, 0, 0, 1, 0);
    chk("R8 first mret m_ie/m_pie/pp", {28'd0, m_ie, m_pie, m_prev_mode}, 32'h4);
    drive(0, 0, 0, 0, 0, 1, 0);
    chk("R8 second mret m_ie", {31'd0, m_ie}, 32'h1);
    drive(0, 0, 0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0, 0, 1);
    chk("R9 sret s_ie/s_pie", {30'd0, s_ie, s_pie}, 32'h3);
    chk("R9 sret to user", {30'd0, cur_mode}, 32'h0);
    drive(1, 0, 5'd2, 32'h5000, 32'h0, 0, 0);
    chk("R7 s entry s_ie/s_pie", {30'd0, s_ie, s_pie}, 32'h1);
    chk("R7 m untouched", {30'd0, m_ie, m_pie}, 32'h3);
    drive(0, 0, 0, 0, 0, 0, 1);
    chk("R9 sret restores s_ie", {31'd0, s_ie}, 32'h1);
    drive(1, 1, 5'd3, 32'h6000, 32'h0, 0, 0);
    chk("R7 m entry m_ie/m_pie", {30'd0, m_ie, m_pie}, 32'h1);
    chk("R7 s untouched", {30'd0, s_ie, s_pie}, 32'h3);
    drive(0, 0, 0, 0, 0, 1, 0);
    chk("R8 mret restores m_ie", {31'd0, m_ie}, 32'h1);
    chk("R8 mret to user", {30'd0, cur_mode}, 32'h0);

    // R10: trap with return in the same cycle
    drive(1, 0, 5'd2, 32'h7000, 32'h0, 1, 0);
    chk("R10 trap wins mode", {30'd0, cur_mode}, 32'h1);
    chk("R10 trap wins pc", pc_next, 32'h200);
    // R10: both returns, machine return wins; supervisor state untouched
    drive(0, 0, 0, 0, 0, 1, 1);
    chk("R10 mret wins pc", pc_next, 32'h6000);
    chk("R10 s state kept", {30'd0, s_ie, s_pie}, 32'h1);

    // R11 idle
    drive(0, 0, 0, 0, 0, 0, 0);
    chk("R11 idle valid", {31'd0, pc_valid}, 32'h0);
    chk("R11 idle mode", {30'd0, cur_mode}, 32'h0);
    chk("R11 idle epc", s_epc, 32'h7000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule